// File: doc/BRIEF.md
# Synchronous Burst SRAM with Byte Writes

A single-clock static RAM model whose word is four 9-bit lanes. Every pin is registered on the rising clock edge. The core then acts on the registered values in the next cycle. Either of two address strobes opens a burst. A 2-bit counter, stepped by an active-low advance input, then produces up to four addresses. These follow either a wrapping-increment or an XOR order. The order is chosen by a mode pin that is captured with the burst start.

Writes can be global or lane-masked. Three chip enables allow depth expansion. A strobe seen while any enable is inactive drops the device to idle in one cycle. Read data drives the output a parameterised number of cycles after capture. The output is released during writes and while idle.

Top module: `sync_burst_sram`

## Requirements
- R1: All inputs are captured at a rising edge k. Read data for the access at edge k is driven with `dq_oe_o` high after edge k+RD_LAT, and stays for exactly one cycle.
- R2: With `gwr_ni` high and `bwe_ni` low, lane i (bits 9i+8..9i) is written only when `bw_ni[i]` is low. Other lanes keep their contents.
- R3: With `gwr_ni` low, all four lanes are written, whatever `bwe_ni` and `bw_ni` say.
- R4: A start is `pstrb_ni` low with `ce_ni` low, or `cstrb_ni` low. With the chip selected, a start loads `addr_i`, clears the counter and latches `mode_i`. A processor-strobe start is always a read. A cache-strobe start reads or writes according to the write controls.
- R5: `pstrb_ni` low while `ce_ni` is high is not a start. The burst base is kept, and the cycle acts as a burst continuation.
- R6: In a continuation, `adv_ni` low steps the 2-bit counter modulo 4 before the access. `adv_ni` high reuses the current address.
- R7: Burst address = base upper bits, with low two bits `(base+cnt) mod 4` when mode was low, or `base XOR cnt` when mode was high.
- R8: A start with any of `ce_ni` low, `ce2_i` high, `ce3_ni` low false ends the burst. Later cycles with no start perform no read and no write.
- R9: `dq_oe_o` is low for write cycles and idle cycles. `dq_o` is high-impedance whenever `dq_oe_o` is low.
- R10: While `rst_ni` is low and after its release, the device is idle with `dq_oe_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | AW | Word address |
| wdata_i | input | 36 | Write data, four 9-bit lanes |
| pstrb_ni | input | 1 | Processor address strobe, active low |
| cstrb_ni | input | 1 | Controller address strobe, active low |
| adv_ni | input | 1 | Burst advance, active low |
| ce_ni | input | 1 | Primary chip enable, active low |
| ce2_i | input | 1 | Chip enable, active high |
| ce3_ni | input | 1 | Chip enable, active low |
| gwr_ni | input | 1 | Global write, active low |
| bwe_ni | input | 1 | Byte write enable, active low |
| bw_ni | input | 4 | Per-lane write select, active low |
| mode_i | input | 1 | Burst order: 0 linear, 1 interleaved |
| dq_o | output | 36 | Read data, high-impedance when not driven |
| dq_oe_o | output | 1 | Read data drive enable |

## Verification
The bench runs bursts in both orders. Starts are placed at offsets 0, 1, 2 and 3, and each burst is advanced through a full wrap. This separates the additive order from the XOR order, which agree only at some offsets. Hold cycles, and a processor strobe with the primary enable high, show whether the counter and base are kept. Lane-masked writes, an empty mask and a global write with a conflicting mask show which lanes change. Deselects through two different enables, followed by advance and write attempts, show that idle cycles touch neither the output nor the array.

// File: rtl/sbs_pkg.sv
package sbs_pkg;
  typedef struct packed {
    logic pstrb_n;
    logic cstrb_n;
    logic adv_n;
    logic ce_n;
    logic ce2;
    logic ce3_n;
    logic gw_n;
    logic bwe_n;
    logic mode;
  } ctl_t;

  localparam ctl_t CTL_IDLE = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0};

  typedef enum logic [1:0] {ACC_NONE, ACC_RD, ACC_WR} acc_e;

  function automatic logic [1:0] burst_ofs(logic [1:0] base, logic [1:0] cnt, logic ilv);
    return ilv ? (base ^ cnt) : (base + cnt);
  endfunction
endpackage

// File: rtl/sbs_in_reg.sv
module sbs_in_reg
  import sbs_pkg::*;
#(
  parameter int AW    = 6,
  parameter int LANES = 4,
  parameter int DW    = 36
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  ctl_t             ctl_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic [LANES-1:0] bw_n_i,
  output ctl_t             ctl_o,
  output logic [AW-1:0]    addr_o,
  output logic [DW-1:0]    wdata_o,
  output logic [LANES-1:0] bw_n_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_o   <= CTL_IDLE;
      addr_o  <= '0;
      wdata_o <= '0;
      bw_n_o  <= '1;
    end else begin
      ctl_o   <= ctl_i;
      addr_o  <= addr_i;
      wdata_o <= wdata_i;
      bw_n_o  <= bw_n_i;
    end
  end
endmodule

// File: rtl/sbs_burst_ctl.sv
module sbs_burst_ctl
  import sbs_pkg::*;
#(
  parameter int AW    = 6,
  parameter int LANES = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  ctl_t             ctl_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [LANES-1:0] bw_n_i,
  output acc_e             acc_o,
  output logic [AW-1:0]    acc_addr_o,
  output logic [LANES-1:0] wmask_o
);
  logic          active_q, mode_q;
  logic [AW-1:0] base_q;
  logic [1:0]    cnt_q, cnt_nxt;
  logic          sel, p_start, start, wr;

  assign sel     = !ctl_i.ce_n && ctl_i.ce2 && !ctl_i.ce3_n;
  assign p_start = !ctl_i.pstrb_n && !ctl_i.ce_n;
  assign start   = p_start || !ctl_i.cstrb_n;
  assign wr      = !ctl_i.gw_n || (!ctl_i.bwe_n && !(&bw_n_i));
  assign cnt_nxt = ctl_i.adv_n ? cnt_q : cnt_q + 2'd1;

  always_comb begin
    if (!ctl_i.gw_n)       wmask_o = '1;
    else if (!ctl_i.bwe_n) wmask_o = ~bw_n_i;
    else                   wmask_o = '0;
  end

  always_comb begin
    acc_o      = ACC_NONE;
    acc_addr_o = addr_i;
    if (start) begin
      if (sel) acc_o = (p_start || !wr) ? ACC_RD : ACC_WR;
    end else if (active_q) begin
      acc_o      = wr ? ACC_WR : ACC_RD;
      acc_addr_o = {base_q[AW-1:2], burst_ofs(base_q[1:0], cnt_nxt, mode_q)};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      mode_q   <= 1'b0;
      base_q   <= '0;
      cnt_q    <= '0;
    end else if (start) begin
      active_q <= sel;
      if (sel) begin
        base_q <= addr_i;
        cnt_q  <= '0;
        mode_q <= ctl_i.mode;
      end
    end else if (active_q) begin
      cnt_q <= cnt_nxt;
    end
  end

  // R4
  load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start && sel) |=> (active_q && cnt_q == 2'd0 && base_q == $past(addr_i)));
  // R8
  desel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start && !sel) |=> !active_q);
  // R6
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && !start && ctl_i.adv_n) |=> $stable(cnt_q));
  // R6
  wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && !start && !ctl_i.adv_n && cnt_q == 2'd3) |=> cnt_q == 2'd0);
  // R5
  p_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctl_i.pstrb_n && ctl_i.ce_n && ctl_i.cstrb_n) |=> $stable(base_q));
endmodule

// File: rtl/sbs_array.sv
module sbs_array #(
  parameter int AW     = 6,
  parameter int LANE_W = 9,
  parameter int LANES  = 4,
  localparam int DW    = LANE_W * LANES,
  localparam int DEPTH = 1 << AW
) (
  input  logic             clk_i,
  input  logic             we_i,
  input  logic [LANES-1:0] wmask_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [DW-1:0]    rdata_o
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    always_ff @(posedge clk_i) begin
      if (we_i && wmask_i[l]) mem[addr_i] <= wdata_i[l*LANE_W +: LANE_W];
    end
    assign rdata_o[l*LANE_W +: LANE_W] = mem[addr_i];
  end
endmodule

// File: rtl/sbs_rd_pipe.sv
module sbs_rd_pipe #(
  parameter int DW  = 36,
  parameter int LAT = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          vld_i,
  input  logic [DW-1:0] data_i,
  output logic          vld_o,
  output logic [DW-1:0] data_o
);
  logic [LAT-1:0] v_q;
  logic [DW-1:0]  d_q [LAT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v_q <= '0;
      for (int i = 0; i < LAT; i++) d_q[i] <= '0;
    end else begin
      v_q[0] <= vld_i;
      d_q[0] <= data_i;
      for (int i = 1; i < LAT; i++) begin
        v_q[i] <= v_q[i-1];
        d_q[i] <= d_q[i-1];
      end
    end
  end

  assign vld_o  = v_q[LAT-1];
  assign data_o = d_q[LAT-1];

  // R10
  rst_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> !vld_o);
endmodule

// File: rtl/sync_burst_sram.sv
module sync_burst_sram
  import sbs_pkg::*;
#(
  parameter int AW     = 6,
  parameter int LANE_W = 9,
  parameter int LANES  = 4,
  parameter int RD_LAT = 2,
  localparam int DW    = LANE_W * LANES
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [AW-1:0]    addr_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic             pstrb_ni,
  input  logic             cstrb_ni,
  input  logic             adv_ni,
  input  logic             ce_ni,
  input  logic             ce2_i,
  input  logic             ce3_ni,
  input  logic             gwr_ni,
  input  logic             bwe_ni,
  input  logic [LANES-1:0] bw_ni,
  input  logic             mode_i,
  output logic [DW-1:0]    dq_o,
  output logic             dq_oe_o
);
  ctl_t             ctl_d, ctl_q;
  logic [AW-1:0]    addr_q, acc_addr;
  logic [DW-1:0]    wdata_q, rdata, pipe_data;
  logic [LANES-1:0] bw_n_q, wmask;
  acc_e             acc;

  assign ctl_d = '{pstrb_ni, cstrb_ni, adv_ni, ce_ni, ce2_i, ce3_ni, gwr_ni, bwe_ni, mode_i};

  sbs_in_reg #(.AW(AW), .LANES(LANES), .DW(DW)) u_in (
    .clk_i, .rst_ni, .ctl_i(ctl_d), .addr_i, .wdata_i, .bw_n_i(bw_ni),
    .ctl_o(ctl_q), .addr_o(addr_q), .wdata_o(wdata_q), .bw_n_o(bw_n_q)
  );

  sbs_burst_ctl #(.AW(AW), .LANES(LANES)) u_ctl (
    .clk_i, .rst_ni, .ctl_i(ctl_q), .addr_i(addr_q), .bw_n_i(bw_n_q),
    .acc_o(acc), .acc_addr_o(acc_addr), .wmask_o(wmask)
  );

  sbs_array #(.AW(AW), .LANE_W(LANE_W), .LANES(LANES)) u_mem (
    .clk_i, .we_i(acc == ACC_WR), .wmask_i(wmask), .addr_i(acc_addr),
    .wdata_i(wdata_q), .rdata_o(rdata)
  );

  sbs_rd_pipe #(.DW(DW), .LAT(RD_LAT)) u_pipe (
    .clk_i, .rst_ni, .vld_i(acc == ACC_RD), .data_i(rdata),
    .vld_o(dq_oe_o), .data_o(pipe_data)
  );

  assign dq_o = dq_oe_o ? pipe_data : 'z;

  // R9
  wr_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc == ACC_WR) |=> !u_pipe.v_q[0]);
endmodule

// File: tb/sim_sync_burst_sram.sv
module sim_sync_burst_sram;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 6, LW = 9, NL = 4, DW = 36, LAT = 2;
  localparam int NV = 48, NSTEP = NV + LAT + 3;
  // kinds: 0 hold, 1 ctl-strobe start, 2 proc-strobe start, 3 advance,
  // 5 deselect via ce2, 6 proc strobe with ce_n high + advance, 7 deselect via ce3
  function automatic logic [15:0] ev(int k, bit m, int a, logic [3:0] bm, bit g);
    return {4'(k), m, 6'(a), bm, g};
  endfunction

  localparam logic [15:0] VEC [NV] = '{
    ev(1,0,16,4'h0,1), ev(3,0,0,4'h0,1), ev(3,0,0,4'h0,1), ev(3,0,0,4'h0,1),
    ev(1,0,20,4'h0,1), ev(3,0,0,4'h0,1), ev(3,0,0,4'h0,1), ev(3,0,0,4'h0,1),
    ev(5,0,0,4'h0,0),
    ev(2,0,17,4'h0,1), ev(3,0,0,4'h0,0), ev(3,0,0,4'h0,0), ev(3,0,0,4'h0,0), ev(3,0,0,4'h0,0),
    ev(2,1,22,4'h0,0), ev(3,0,0,4'h0,0), ev(3,0,0,4'h0,0), ev(3,0,0,4'h0,0), ev(0,0,0,4'h0,0),
    ev(1,1,19,4'h0,0), ev(3,0,0,4'h0,0), ev(3,0,0,4'h0,0), ev(3,0,0,4'h0,0),
    ev(1,0,18,4'h5,0), ev(0,0,0,4'h8,0), ev(0,0,0,4'h0,0), ev(3,0,0,4'h1,1),
    ev(6,0,40,4'h0,0), ev(0,0,0,4'h0,0),
    ev(5,0,0,4'h0,0), ev(3,0,0,4'h0,0), ev(0,0,0,4'h0,1),
    ev(1,1,16,4'h0,0), ev(3,0,0,4'h0,0), ev(3,0,0,4'h0,0), ev(3,0,0,4'h0,0),
    ev(2,1,21,4'h0,0), ev(3,0,0,4'h0,0), ev(3,0,0,4'h0,0), ev(3,0,0,4'h0,0),
    ev(1,0,23,4'h0,0), ev(3,0,0,4'h0,0), ev(3,0,0,4'h0,0), ev(3,0,0,4'h0,0),
    ev(7,0,0,4'h0,0), ev(3,0,0,4'h0,0), ev(0,0,0,4'h0,0), ev(0,0,0,4'h0,0)
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0, dq;
  logic psn = 1, csn = 1, advn = 1, cen = 1, ce2 = 0, ce3n = 1, gwn = 1, bwen = 1, mode = 0, oe;
  logic [NL-1:0] bwn = '1;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [DW-1:0] ref_mem [1<<AW];
  bit r_act = 0, r_mode = 0;
  logic [AW-1:0] r_base = '0;
  logic [1:0] r_cnt = '0;
  bit exp_oe [NSTEP];
  logic [DW-1:0] exp_d [NSTEP];
  int exp_tag [NSTEP];

  always #(CLK_PERIOD/2) clk = ~clk;

  sync_burst_sram #(.AW(AW), .LANE_W(LW), .LANES(NL), .RD_LAT(LAT)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata), .pstrb_ni(psn),
    .cstrb_ni(csn), .adv_ni(advn), .ce_ni(cen), .ce2_i(ce2), .ce3_ni(ce3n),
    .gwr_ni(gwn), .bwe_ni(bwen), .bw_ni(bwn), .mode_i(mode), .dq_o(dq), .dq_oe_o(oe)
  );

  task automatic check(bit ok, int tag, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL R%0d %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // R1 timing: access at edge s is checked after edge s+LAT, i.e. at step s+LAT+1
  task automatic compare(int s);
    int idx = s - 1 - LAT;
    if (idx < 0) check(oe == 1'b0, 10, "idle after reset oe", {35'd0, oe}, '0);
    else if (exp_oe[idx]) begin
      check(oe == 1'b1, 1, "read oe", {35'd0, oe}, 36'd1);
      check(dq === exp_d[idx], exp_tag[idx], "read data", dq, exp_d[idx]);
    end else check(oe == 1'b0, exp_tag[idx], "oe released", {35'd0, oe}, '0);
  endtask

  task automatic step(logic [15:0] v, int s);
    int k = int'(v[15:12]);
    bit p_st, st, sl, wr;
    logic [NL-1:0] msk;
    logic [AW-1:0] aa;
    int acc = 0, tag = 8;
    compare(s);
    psn = 1; csn = 1; advn = 1; cen = 0; ce2 = 1; ce3n = 0;
    mode = v[11]; addr = v[10:5];
    gwn = !v[0]; bwen = (v[4:1] == 4'h0); bwn = ~v[4:1];
    for (int l = 0; l < NL; l++) wdata[l*LW +: LW] = 9'(s * 37 + l * 61 + 5);
    case (k)
      1: csn = 0;
      2: psn = 0;
      3: advn = 0;
      5: begin csn = 0; ce2 = 0; end
      6: begin psn = 0; cen = 1; advn = 0; end
      7: begin csn = 0; ce3n = 1; end
      default: ;
    endcase
    p_st = !psn && !cen; st = p_st || !csn; sl = !cen && ce2 && !ce3n;
    wr = !gwn || (!bwen && bwn != '1);
    msk = !gwn ? '1 : (!bwen ? ~bwn : '0);
    aa = addr;
    if (st && !sl) r_act = 0;                       // R8
    else if (st) begin                              // R4
      r_base = addr; r_cnt = 0; r_mode = mode; r_act = 1;
      acc = (p_st || !wr) ? 1 : 2; tag = 4;
    end else if (r_act) begin                       // R5 R6 R7
      if (!advn) r_cnt++;
      aa = {r_base[AW-1:2], r_mode ? (r_base[1:0] ^ r_cnt) : (r_base[1:0] + r_cnt)};
      acc = wr ? 2 : 1; tag = 7;
    end
    exp_oe[s] = (acc == 1); exp_d[s] = '0;
    if (acc == 2) begin                             // R2 R3 R9
      tag = !gwn ? 3 : 2;
      for (int l = 0; l < NL; l++)
        if (msk[l]) ref_mem[aa][l*LW +: LW] = wdata[l*LW +: LW];
    end else if (acc == 1) exp_d[s] = ref_mem[aa];
    exp_tag[s] = tag;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(oe == 1'b0, 10, "oe in reset", {35'd0, oe}, '0);  // R10
    rst_n = 1'b1;
    for (int s = 0; s < NSTEP; s++) begin
      @(negedge clk);
      if (s < NV) step(VEC[s], s);
      else step(ev(0, 0, 0, 4'h0, 0), s);
    end
    // R10: reset mid-activity returns to idle
    @(negedge clk); psn = 0; cen = 0; addr = 6'd16;
    @(negedge clk); psn = 1; rst_n = 1'b0;
    @(negedge clk); check(oe == 1'b0, 10, "oe after reset", {35'd0, oe}, '0);
    rst_n = 1'b1;
    repeat (LAT + 1) @(negedge clk);
    check(oe == 1'b0, 10, "no read after reset", {35'd0, oe}, '0);
    done = 1;
    summary();
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL R1 watchdog expired: actual 0 expected 1");
      summary();
      $finish;
    end
  end
endmodule